// File: doc/BRIEF.md
# Trigger-Armed Frame Transfer Engine

This block moves one frame of 32-bit words at a time between a host processor and an external device, using a shared buffer of up to 256 words as the staging area. The host programs a frame length, given as the index of the last word, and a direction into an operation register. The host then fills the buffer, for outbound frames, or waits for it to be filled, for inbound frames. No explicit start command exists. The hand-over of the buffer happens when the host touches the last word of the frame, called the trigger word, through a decode of the buffer address.

Outbound frames leave on a valid/ready word stream. The bench may hold `tx_ready` low for any number of cycles. While it is low, `tx_valid`, `tx_data` and `tx_addr` hold their values, and a word moves only in a cycle where both `tx_valid` and `tx_ready` are high. Inbound words arrive on a second valid/ready stream. `rx_ready` is high only while the block is collecting a frame, and a word is stored only in a cycle where both `rx_valid` and `rx_ready` are high. Each word on either stream carries an external address taken from a counter. The counter either advances by one per word or stays fixed. The control register reports the current word position, a busy flag and a done flag. The done flag is also driven on `irq`.

Top module: `frame_xfer_engine`

## Requirements
- R1: After reset the three registers read 0, and `tx_valid`, `rx_ready` and `irq` are low.
- R2: The buffer word index is `buf_addr[9:2]`. Bits 17:10 and 1:0 are ignored, both for storage and for the trigger match, so every alias of a word reaches the same entry.
- R3: Register offset 0 holds the trigger in bits 7:0 (frame length minus one) and the direction in bit 8. Writing it with bit 8 set arms the outbound direction. A later host buffer write whose index equals the trigger stores its data and starts the frame. The frame does not start on writes to other indices, on reads, or on a trigger-index write while the block is not armed.
- R4: An outbound frame sends buffer words 0 through the trigger, in order, on the tx stream. While `tx_ready` is low, `tx_valid` stays high and the data and address stay stable.
- R5: Writing offset 0 with bit 8 clear hands the buffer to the external side and raises `rx_ready`. Accepted rx words are stored at indices 0 upward. After trigger+1 words, `rx_ready` falls and the host reads those words back from the buffer.
- R6: After an inbound frame completes, a host read of the trigger index returns the buffer to the external side for the next frame. Host reads of any other index do not.
- R7: Offset 2 sets the external address, which appears on `tx_addr` and `rx_addr`. When control bit 0 is set, the address advances by 1 after each moved word. When the bit is clear, the address stays fixed.
- R8: Control register offset 1 shows, in bits 15:8, the index of the word currently being moved (0 when idle), and shows busy in bit 2.
- R9: Control bit 1 (done) is set when the last word of a frame moves, and `irq` follows it. Writing 1 to that bit clears it, and so does an accepted write to offset 0.
- R10: While a frame is in flight, host buffer writes are ignored, and writes to offset 0, offset 2 and control bit 0 are ignored.
- R11: A full 256-word frame (trigger 255) transfers completely, and the external address wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 operation, 1 control, 2 external address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| buf_en | input | 1 | Host buffer access enable |
| buf_we | input | 1 | Host buffer write (1) or read (0) |
| buf_addr | input | 18 | Host byte address into the buffer window |
| buf_wdata | input | 32 | Host buffer write data |
| buf_rdata | output | 32 | Host buffer read data, one cycle after the read |
| tx_valid | output | 1 | Outbound word valid |
| tx_ready | input | 1 | Outbound word accepted |
| tx_data | output | 32 | Outbound word |
| tx_addr | output | 32 | External address for the outbound word |
| rx_valid | input | 1 | Inbound word valid |
| rx_ready | output | 1 | Block can take an inbound word |
| rx_data | input | 32 | Inbound word |
| rx_addr | output | 32 | External address for the inbound word |
| irq | output | 1 | Done flag |

## Verification
The bench reaches the trigger through random alias addresses. A decode that used the whole address would then never start, or would start on the wrong word. It also pokes the trigger word while an outbound frame is still draining. A design that let that write through would send corrupted data or restart the frame. Inbound frames are read back with every non-trigger word first, so a block that returned the buffer on any read would raise `rx_ready` too early. The bench also covers one-word frames and a full 256-word frame whose address wraps, which exposes off-by-one errors in the last-word compare and in the counter width.

// File: rtl/fxe_pkg.sv
package fxe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM_OUT,
    ST_OUT_RUN,
    ST_IN_RUN,
    ST_IN_READ
  } fxe_state_e;

  localparam logic [1:0] REG_OP    = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_XADDR = 2'd2;

  localparam int CTRL_INC_BIT  = 0;
  localparam int CTRL_DONE_BIT = 1;
  localparam int CTRL_BUSY_BIT = 2;
  localparam int CTRL_POS_LSB  = 8;
endpackage

// File: rtl/fxe_trig_dec.sv
module fxe_trig_dec #(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int HADDR_W = 18
) (
  input  logic [HADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]   trig,
  output logic [IDX_W-1:0]   idx,
  output logic               hit
);
  localparam int LSB = $clog2(WORD_W / 8);
  localparam int TOP = LSB + IDX_W;

  assign idx = addr[LSB +: IDX_W];
  assign hit = (idx == trig);

  // byte-lane bits never select a word
  logic unused_lane;
  assign unused_lane = ^addr[LSB-1:0];

  // bits above the index only alias the window
  generate
    if (HADDR_W > TOP) begin : g_alias
      logic unused_alias;
      assign unused_alias = ^addr[HADDR_W-1:TOP];
    end
  endgenerate
endmodule

// File: rtl/fxe_buf.sv
module fxe_buf #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata,
  input  logic [IDX_W-1:0]  bidx,
  output logic [WORD_W-1:0] bdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // host side: registered read, old data on a same-address write
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end

  // bus side: direct read so a stalled word needs no refetch
  assign bdata = mem[bidx];
endmodule

// File: rtl/fxe_regs.sv
module fxe_regs #(
  parameter int REG_W   = 32,
  parameter int IDX_W   = 8,
  parameter int EADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               busy,
  input  logic               step,
  input  logic               done_set,
  input  logic [IDX_W-1:0]   pos,
  output logic               op_wr_ok,
  output logic [IDX_W-1:0]   trig,
  output logic               dir,
  output logic               inc,
  output logic               done,
  output logic [EADDR_W-1:0] xaddr,
  output logic [REG_W-1:0]   reg_rdata
);
  import fxe_pkg::*;

  localparam int DIR_BIT = IDX_W;

  logic wr_ctrl, wr_xaddr, done_clr;

  assign op_wr_ok = reg_wr && (reg_addr == REG_OP) && !busy;
  assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
  assign wr_xaddr = reg_wr && (reg_addr == REG_XADDR) && !busy;
  assign done_clr = op_wr_ok || (wr_ctrl && reg_wdata[CTRL_DONE_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig <= '0;
      dir  <= 1'b0;
    end else if (op_wr_ok) begin
      trig <= reg_wdata[IDX_W-1:0];
      dir  <= reg_wdata[DIR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                inc <= 1'b0;
    else if (wr_ctrl && !busy) inc <= reg_wdata[CTRL_INC_BIT];
  end

  // completion wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b0;
    else if (done_set) done <= 1'b1;
    else if (done_clr) done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            xaddr <= '0;
    else if (step && inc)  xaddr <= xaddr + EADDR_W'(1);
    else if (wr_xaddr)     xaddr <= reg_wdata[EADDR_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_OP: begin
        reg_rdata[IDX_W-1:0] = trig;
        reg_rdata[DIR_BIT]   = dir;
      end
      REG_CTRL: begin
        reg_rdata[CTRL_INC_BIT]              = inc;
        reg_rdata[CTRL_DONE_BIT]             = done;
        reg_rdata[CTRL_BUSY_BIT]             = busy;
        reg_rdata[CTRL_POS_LSB +: IDX_W]     = pos;
      end
      REG_XADDR: reg_rdata = REG_W'(xaddr);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fxe_seq.sv
module fxe_seq #(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_wr_ok,
  input  logic                op_dir,
  input  logic [IDX_W-1:0]    trig,
  input  logic                host_wr_hit,
  input  logic                host_rd_hit,
  input  logic                tx_ready,
  input  logic                rx_valid,
  output fxe_pkg::fxe_state_e st,
  output logic                busy,
  output logic                tx_valid,
  output logic                rx_ready,
  output logic                step,
  output logic                in_wr,
  output logic [IDX_W-1:0]    pos,
  output logic                done_set
);
  import fxe_pkg::*;

  fxe_state_e nxt;
  logic       last;

  assign tx_valid = (st == ST_OUT_RUN);
  assign rx_ready = (st == ST_IN_RUN);
  assign busy     = tx_valid || rx_ready;
  assign in_wr    = rx_ready && rx_valid;
  assign step     = (tx_valid && tx_ready) || in_wr;
  assign last     = (pos == trig);
  assign done_set = step && last;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE, ST_ARM_OUT, ST_IN_READ: begin
        if (op_wr_ok)
          nxt = op_dir ? ST_ARM_OUT : ST_IN_RUN;
        else if (st == ST_ARM_OUT && host_wr_hit)
          nxt = ST_OUT_RUN;
        else if (st == ST_IN_READ && host_rd_hit)
          nxt = ST_IN_RUN;
      end
      ST_OUT_RUN: if (done_set) nxt = ST_IDLE;
      ST_IN_RUN:  if (done_set) nxt = ST_IN_READ;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= last ? '0 : pos + IDX_W'(1);
  end
endmodule

// File: rtl/frame_xfer_engine.sv
module frame_xfer_engine #(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int HADDR_W = 18,
  parameter int EADDR_W = 32,
  parameter int REG_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               buf_en,
  input  logic               buf_we,
  input  logic [HADDR_W-1:0] buf_addr,
  input  logic [WORD_W-1:0]  buf_wdata,
  output logic [WORD_W-1:0]  buf_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [WORD_W-1:0]  tx_data,
  output logic [EADDR_W-1:0] tx_addr,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [WORD_W-1:0]  rx_data,
  output logic [EADDR_W-1:0] rx_addr,
  output logic               irq
);
  import fxe_pkg::*;

  fxe_state_e         st;
  logic               busy, step, in_wr, done_set, done;
  logic               op_wr_ok, dir, inc;
  logic [IDX_W-1:0]   trig, pos, hidx;
  logic               hit;
  logic [EADDR_W-1:0] xaddr;
  logic               host_wr_ok, host_re;
  logic               mem_we;
  logic [IDX_W-1:0]   mem_widx;
  logic [WORD_W-1:0]  mem_wdata;

  assign host_wr_ok = buf_en && buf_we && !busy;
  assign host_re    = buf_en && !buf_we;

  // ownership keeps the two writers apart
  assign mem_we    = host_wr_ok || in_wr;
  assign mem_widx  = in_wr ? pos : hidx;
  assign mem_wdata = in_wr ? rx_data : buf_wdata;

  fxe_trig_dec #(.WORD_W(WORD_W), .IDX_W(IDX_W), .HADDR_W(HADDR_W)) u_dec (
    .addr (buf_addr),
    .trig (trig),
    .idx  (hidx),
    .hit  (hit)
  );

  fxe_regs #(.REG_W(REG_W), .IDX_W(IDX_W), .EADDR_W(EADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .step      (step),
    .done_set  (done_set),
    .pos       (pos),
    .op_wr_ok  (op_wr_ok),
    .trig      (trig),
    .dir       (dir),
    .inc       (inc),
    .done      (done),
    .xaddr     (xaddr),
    .reg_rdata (reg_rdata)
  );

  fxe_seq #(.IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_wr_ok    (op_wr_ok),
    .op_dir      (reg_wdata[IDX_W]),
    .trig        (trig),
    .host_wr_hit (host_wr_ok && hit),
    .host_rd_hit (host_re && hit),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .st          (st),
    .busy        (busy),
    .tx_valid    (tx_valid),
    .rx_ready    (rx_ready),
    .step        (step),
    .in_wr       (in_wr),
    .pos         (pos),
    .done_set    (done_set)
  );

  fxe_buf #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .widx  (mem_widx),
    .wdata (mem_wdata),
    .re    (host_re),
    .ridx  (hidx),
    .rdata (buf_rdata),
    .bidx  (pos),
    .bdata (tx_data)
  );

  assign tx_addr = xaddr;
  assign rx_addr = xaddr;
  assign irq     = done;

  logic unused_dir;
  assign unused_dir = dir ^ (st == ST_IDLE);
endmodule

// File: rtl/fxe_chk.sv
module fxe_chk #(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int EADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [WORD_W-1:0]  tx_data,
  input logic [EADDR_W-1:0] tx_addr,
  input logic               rx_valid,
  input logic               rx_ready,
  input logic               irq,
  input logic               buf_en,
  input logic               buf_we,
  input logic               busy,
  input logic [IDX_W-1:0]   pos,
  input logic [IDX_W-1:0]   trig,
  input logic               inc
);
  logic hs;
  assign hs = (tx_valid && tx_ready) || (rx_valid && rx_ready);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_addr));

  // R5
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  // R3
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(buf_en && buf_we));

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hs));

  // R7
  addr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !inc |=> $stable(tx_addr));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && inc |=> tx_addr == $past(tx_addr) + EADDR_W'(1));

  // R8
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pos <= trig);
endmodule

bind frame_xfer_engine fxe_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W), .EADDR_W(EADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_addr  (tx_addr),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .irq      (irq),
  .buf_en   (buf_en),
  .buf_we   (buf_we),
  .busy     (busy),
  .pos      (pos),
  .trig     (trig),
  .inc      (inc)
);

// File: tb/sim_frame_xfer_engine.sv
module sim_frame_xfer_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        buf_en = 1'b0, buf_we = 1'b0;
  logic [17:0] buf_addr = '0;
  logic [31:0] buf_wdata = '0, buf_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_data, tx_addr;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_data = '0, rx_addr;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  frame_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_en(buf_en),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_addr(tx_addr), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_addr(rx_addr), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int frame, input int i);
    return {frame[15:0], i[15:0]} ^ 32'hA5C3_0F96;
  endfunction

  function automatic logic [17:0] baddr(input int idx, input int alias_v);
    return {alias_v[7:0], idx[7:0], alias_v[9:8]};
  endfunction

  function automatic logic [31:0] op_val(input bit dir, input int trig);
    return {23'd0, dir, trig[7:0]};
  endfunction

  function automatic logic [31:0] ctrl_val(input int pos, input bit busy, input bit done, input bit inc);
    return {16'd0, pos[7:0], 5'd0, busy, done, inc};
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic buf_write(input logic [17:0] a, input logic [31:0] d);
    @(negedge clk);
    buf_en = 1'b1; buf_we = 1'b1; buf_addr = a; buf_wdata = d;
    @(posedge clk); #1;
    buf_en = 1'b0; buf_we = 1'b0;
  endtask

  task automatic buf_read(input logic [17:0] a, output logic [31:0] d);
    @(negedge clk);
    buf_en = 1'b1; buf_we = 1'b0; buf_addr = a;
    @(posedge clk); #1;
    buf_en = 1'b0;
    d = buf_rdata;
  endtask

  task automatic run_out(input int trig, input bit inc, input logic [31:0] base, input int frame, input bit poke);
    logic [31:0] d;
    int got, it;
    reg_write(2'd2, base);
    reg_write(2'd1, {30'd0, 1'b1, inc});
    reg_write(2'd0, op_val(1'b1, trig));
    for (int i = 0; i < trig; i++) buf_write(baddr(i, int'($urandom)), pat(frame, i));
    if (trig > 0) begin
      buf_read(baddr(trig, int'($urandom)), d);
      @(negedge clk); #1;
      chk("R3", "read or other index started frame", 32'(tx_valid), 32'd0);
    end
    buf_write(baddr(trig, int'($urandom)), pat(frame, trig));
    got = 0; it = 0;
    while (got <= trig) begin
      @(negedge clk);
      tx_ready = ($urandom % 3) != 0;
      reg_addr = 2'd1;
      if (poke && trig > 0) begin
        buf_en = (it == 0); buf_we = (it == 0);
        buf_addr = baddr(trig, 0); buf_wdata = 32'hDEAD_BEEF;
      end
      #1;
      if (tx_valid !== 1'b1) chk("R4", "tx_valid during frame", 32'(tx_valid), 32'd1);
      if (tx_ready) begin
        chk("R4", "tx_data", tx_data, pat(frame, got));
        chk("R7", "tx_addr", tx_addr, base + (inc ? 32'(got) : 32'd0));
        got++;
      end else begin
        // R8 position and busy during a stall
        chk("R8", "ctrl while stalled", reg_rdata, ctrl_val(got, 1'b1, 1'b0, inc));
      end
      it++;
    end
    @(negedge clk);
    tx_ready = 1'b0; buf_en = 1'b0; buf_we = 1'b0;
    #1;
    chk("R9", "irq after frame", 32'(irq), 32'd1);
    chk("R4", "tx_valid after frame", 32'(tx_valid), 32'd0);
    reg_read(2'd1, d);
    chk("R8", "ctrl after frame", d, ctrl_val(0, 1'b0, 1'b1, inc));
    reg_read(2'd2, d);
    chk("R7", "final address", d, base + (inc ? 32'(trig + 1) : 32'd0));
  endtask

  task automatic run_in(input int trig, input bit inc, input logic [31:0] base, input int frame,
                        input bit arm, input bit final_read);
    logic [31:0] d;
    int got;
    if (arm) begin
      reg_write(2'd2, base);
      reg_write(2'd1, {30'd0, 1'b1, inc});
      reg_write(2'd0, op_val(1'b0, trig));
    end
    got = 0;
    while (got <= trig) begin
      @(negedge clk);
      rx_valid = ($urandom % 3) != 0;
      rx_data = pat(frame, got);
      #1;
      if (rx_valid) begin
        chk("R5", "rx_ready while collecting", 32'(rx_ready), 32'd1);
        chk("R7", "rx_addr", rx_addr, base + (inc ? 32'(got) : 32'd0));
        got++;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
    chk("R5", "rx_ready after frame", 32'(rx_ready), 32'd0);
    chk("R9", "irq after inbound", 32'(irq), 32'd1);
    for (int i = 0; i < trig; i++) begin
      buf_read(baddr(i, int'($urandom)), d);
      chk("R5", "inbound word", d, pat(frame, i));
    end
    // R6 non-trigger reads leave the buffer with the host
    chk("R6", "rx_ready after other reads", 32'(rx_ready), 32'd0);
    if (final_read) begin
      buf_read(baddr(trig, int'($urandom)), d);
      chk("R5", "inbound last word", d, pat(frame, trig));
      chk("R6", "rx_ready after trigger read", 32'(rx_ready), 32'd1);
    end
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    reg_read(2'd0, d); chk("R1", "op reg", d, 32'd0);
    reg_read(2'd1, d); chk("R1", "ctrl reg", d, 32'd0);
    reg_read(2'd2, d); chk("R1", "xaddr reg", d, 32'd0);
    chk("R1", "tx_valid", 32'(tx_valid), 32'd0);
    chk("R1", "rx_ready", 32'(rx_ready), 32'd0);
    chk("R1", "irq", 32'(irq), 32'd0);

    // R3 trigger-index write while not armed
    buf_write(baddr(0, 3), 32'h1111_2222);
    @(negedge clk); #1;
    chk("R3", "unarmed trigger", 32'(tx_valid), 32'd0);

    // outbound with alias addresses (R2) and a busy poke (R10)
    run_out(3, 1'b1, 32'h0000_0100, 1, 1'b1);

    // R9 op write clears done
    reg_write(2'd0, op_val(1'b1, 5));
    @(negedge clk); #1;
    chk("R9", "op write clears irq", 32'(irq), 32'd0);
    run_out(5, 1'b0, 32'hABCD_0000, 2, 1'b1);

    // inbound, then rearm by reading the trigger word
    run_in(6, 1'b1, 32'h0000_2000, 3, 1'b1, 1'b1);
    // R10 register writes ignored while busy
    reg_write(2'd0, op_val(1'b1, 9));
    reg_read(2'd0, d); chk("R10", "op write while busy", d, op_val(1'b0, 6));
    reg_write(2'd2, 32'h0);
    reg_read(2'd2, d); chk("R10", "xaddr write while busy", d, 32'h0000_2007);
    reg_write(2'd1, 32'h2);
    reg_read(2'd1, d); chk("R9", "W1C clears done", d, ctrl_val(0, 1'b1, 1'b0, 1'b1));
    chk("R9", "irq after W1C", 32'(irq), 32'd0);
    run_in(6, 1'b1, 32'h0000_2007, 4, 1'b0, 1'b0);

    // R11 full frame with address wrap
    run_out(255, 1'b1, 32'hFFFF_FF80, 5, 1'b1);

    // single-word frames
    run_out(0, 1'b1, 32'h0000_0040, 6, 1'b0);
    run_in(0, 1'b0, 32'h0000_0050, 7, 1'b1, 1'b0);

    // random frames
    for (int k = 0; k < 8; k++) begin
      int  t;
      bit  dr, ic;
      t  = int'($urandom % 48);
      dr = 1'($urandom);
      ic = 1'($urandom);
      if (dr) run_out(t, ic, $urandom, 10 + k, 1'($urandom));
      else    run_in(t, ic, $urandom, 10 + k, 1'b1, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule